// File: doc/BRIEF.md
# CAN Controller Low-Power Mode Sequencer

This block is the mode-control part of a CAN controller. It takes two low-power requests from a small register bus. The first is sleep, which shuts the controller off the bus and fences its registers. The second is suspend, which keeps the register file alive but stops the controller from driving anything onto the wire. The block decides when each request may safely take effect. It looks at frame completions, lost arbitrations and bus-off recovery, which are reported by the protocol engine. It owns the mode register, a status register and the transmit request set/reset registers. Every other register address is passed through to the rest of the controller.

On the way into sleep, the block clears the transmit request flags and sends a one-cycle clear pulse to the error counters. It wakes when software writes the mode register. It also wakes on a dominant bit sampled on the receive line, if software enabled that. After waking, it stays off the bus until the receive line has shown a run of recessive samples. The frame that woke it is thrown away.

Top module: `can_lpm_seq`

## Requirements
- R1: After reset the block is bus-active with both acknowledges low, the mode register reads 0x0000, both transmit flag registers read zero, and the status register reads 0x8002.
- R2: Writing the mode register with bit 0 (sleep request) set while `bus_busy` is low raises `sleep_ack` within three clock cycles. `bus_active` falls at the same time.
- R3: While asleep, a read at address 1 (status) returns 0xF040. A read at any other address returns 0x0000, including pass-through addresses.
- R4: While asleep, writes to every address except 0 (mode) leave all state unchanged and never raise `ext_wr`. While awake, a write to an address of 4 or more raises `ext_wr` for that cycle.
- R5: On sleep entry the transmit request flags (address 2) and abort flags (address 3) are cleared. `err_cnt_clr` pulses for exactly one cycle per entry.
- R6: Any write to the mode register while asleep ends sleep at once. `sleep_ack` falls and the sleep request bit reads back 0. Bit 2 (wake-on-bus enable) keeps the written value.
- R7: With bit 2 of the mode register set, a strobed dominant sample (`can_rx` = 0 with `bit_stb`) while asleep ends sleep. With bit 2 clear, such a sample leaves the block asleep. Recessive samples never wake it.
- R8: After waking, `bus_active` rises on the 11th consecutive strobed recessive sample. A strobed dominant sample restarts the count from zero.
- R9: A sleep request made while `bus_busy` is high takes effect on a `frm_done` pulse with `frm_is_tx` high. It also takes effect on a `frm_done` pulse that follows an `arb_lost` pulse in the same frame. A received frame with no lost arbitration does not let it in.
- R10: Writing mode bit 1 (suspend request) while `bus_busy` is high defers suspend until a `frm_done` pulse. `susp_ack` and `tx_inhibit` then go high, and status bit 0 reads 1.
- R11: While `busoff_rec` is high a pending suspend is not entered. It is entered once recovery ends.
- R12: Writing 0 to mode bit 1 while suspended drops `susp_ack` and `tx_inhibit` and restores `bus_active` within two cycles.
- R13: A write to address 2 or 3 sets the flags under the one bits of the data. A bit of `tx_done_mb` or `abort_done_mb` clears the matching flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid while reg_rd is high |
| ext_wr | output | 1 | Gated write strobe for pass-through registers |
| ext_rdata | input | DATA_W | Read data of pass-through registers |
| can_rx | input | 1 | Receive line level, 1 is recessive |
| bit_stb | input | 1 | One-cycle bit sample strobe |
| bus_busy | input | 1 | A frame is in progress on the bus |
| frm_done | input | 1 | Pulse: current frame completed without error |
| frm_is_tx | input | 1 | Qualifies frm_done: frame was sent by this node |
| arb_lost | input | 1 | Pulse: arbitration lost in the current frame |
| busoff_rec | input | 1 | Bus-off recovery in progress |
| err_passive | input | 1 | Error-passive flag, shown in status bit 2 |
| tx_done_mb | input | NMB | Per-buffer transmit completion, clears request flag |
| abort_done_mb | input | NMB | Per-buffer abort completion, clears abort flag |
| tx_req | output | NMB | Transmit request flags |
| tx_abort | output | NMB | Transmit abort flags |
| err_cnt_clr | output | 1 | Pulse: clear the error counters |
| tx_inhibit | output | 1 | No error frames or acknowledges may be driven |
| sleep_ack | output | 1 | Sleep mode entered |
| susp_ack | output | 1 | Suspend mode entered |
| bus_active | output | 1 | Controller takes part in bus traffic |

## Verification
A wrong mode state shows up at once: `sleep_ack`, `susp_ack` and `bus_active` decode directly from the state register, and the read data of the status address changes to the fixed sleep pattern in the same cycle. A stuck or mis-counting idle counter only shows when the 11th recessive sample arrives, so the bench places a dominant sample after ten recessive ones and checks that the count restarts. A wrong frame-completion qualifier stays hidden until a frame ends with the bus still busy. Each qualifying and non-qualifying completion is therefore driven with `bus_busy` held high.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE     = 3'd0,
    ST_SLEEP_PEND = 3'd1,
    ST_SLEEP      = 3'd2,
    ST_WAKE       = 3'd3,
    ST_SUSP_PEND  = 3'd4,
    ST_SUSP       = 3'd5
  } lpm_state_e;

  // register addresses owned by the sequencer
  localparam int unsigned A_MODE  = 0;
  localparam int unsigned A_STAT  = 1;
  localparam int unsigned A_TXSET = 2;
  localparam int unsigned A_TXRST = 3;
  localparam int unsigned A_OWN_N = 4;

  // mode register bits
  localparam int unsigned MB_SLEEP = 0;
  localparam int unsigned MB_SUSP  = 1;
  localparam int unsigned MB_WAKE  = 2;

  // status register bits (awake)
  localparam int unsigned SB_SUSP_ACK  = 0;
  localparam int unsigned SB_ACTIVE    = 1;
  localparam int unsigned SB_ERR_PASS  = 2;
  localparam int unsigned SB_BUSOFF    = 3;
  localparam int unsigned SB_BUSY      = 4;
  localparam int unsigned SB_SLEEP_ACK = 6;
  localparam int unsigned SB_TX_IDLE   = 15;

  localparam logic [15:0] SLEEP_STATUS = 16'hF040;

endpackage

// File: rtl/lpm_wake_cnt.sv
module lpm_wake_cnt #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic bit_stb,
  input  logic can_rx,
  output logic idle_seen
);
  localparam int unsigned CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d     = cnt_q;
    idle_seen = 1'b0;
    if (!arm) begin
      cnt_d = '0;
    end else if (bit_stb) begin
      if (!can_rx) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        idle_seen = 1'b1;
        cnt_d     = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpm_frame_track.sv
module lpm_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_done,
  input  logic frm_is_tx,
  input  logic arb_lost,
  output logic sleep_evt
);
  logic arb_seen_q, arb_seen_d;

  // a frame ending lets sleep in if it was our own transmission,
  // or a reception that followed a lost arbitration
  always_comb begin
    sleep_evt  = frm_done & (frm_is_tx | arb_seen_q | arb_lost);
    arb_seen_d = arb_seen_q;
    if (frm_done)      arb_seen_d = 1'b0;
    else if (arb_lost) arb_seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arb_seen_q <= 1'b0;
    else        arb_seen_q <= arb_seen_d;
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       susp_req,
  input  logic       wake_en,
  input  logic       mode_wr,
  input  logic       bus_busy,
  input  logic       busoff_rec,
  input  logic       frm_done,
  input  logic       sleep_evt,
  input  logic       bit_stb,
  input  logic       can_rx,
  input  logic       idle_seen,
  output lpm_state_e state_q,
  output logic       enter_sleep,
  output logic       leave_sleep
);
  lpm_state_e state_d;
  logic       bus_wake;

  assign bus_wake = wake_en & bit_stb & ~can_rx;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (susp_req)       state_d = ST_SUSP_PEND;
        else if (sleep_req) state_d = ST_SLEEP_PEND;
      end
      ST_SLEEP_PEND: begin
        if (!sleep_req)                 state_d = ST_ACTIVE;
        else if (!bus_busy || sleep_evt) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (mode_wr || bus_wake) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (idle_seen) state_d = ST_ACTIVE;
      end
      ST_SUSP_PEND: begin
        if (!susp_req)                                  state_d = ST_ACTIVE;
        else if (!busoff_rec && (!bus_busy || frm_done)) state_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (!susp_req) state_d = ST_ACTIVE;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  assign enter_sleep = (state_q != ST_SLEEP) && (state_d == ST_SLEEP);
  assign leave_sleep = (state_q == ST_SLEEP) && (state_d != ST_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ACTIVE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NMB    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ext_wr,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              asleep,
  input  logic              enter_sleep,
  input  logic              leave_sleep,
  input  logic [DATA_W-1:0] status_live,
  input  logic [NMB-1:0]    tx_done_mb,
  input  logic [NMB-1:0]    abort_done_mb,
  output logic              mode_wr,
  output logic              sleep_req,
  output logic              susp_req,
  output logic              wake_en,
  output logic [NMB-1:0]    trs_q,
  output logic [NMB-1:0]    trr_q
);
  logic sel_mode, sel_stat, sel_set, sel_rst, sel_ext;
  logic sleep_req_d, susp_req_d, wake_en_d;
  logic [NMB-1:0] trs_d, trr_d;
  logic wr_ok;

  always_comb begin
    sel_mode = (reg_addr == ADDR_W'(A_MODE));
    sel_stat = (reg_addr == ADDR_W'(A_STAT));
    sel_set  = (reg_addr == ADDR_W'(A_TXSET));
    sel_rst  = (reg_addr == ADDR_W'(A_TXRST));
    sel_ext  = (reg_addr >= ADDR_W'(A_OWN_N));
  end

  // only the mode register stays writable during sleep
  assign wr_ok   = reg_wr & ~asleep;
  assign mode_wr = reg_wr & sel_mode;
  assign ext_wr  = wr_ok & sel_ext;

  always_comb begin
    sleep_req_d = sleep_req;
    susp_req_d  = susp_req;
    wake_en_d   = wake_en;
    if (mode_wr) begin
      sleep_req_d = reg_wdata[MB_SLEEP];
      susp_req_d  = reg_wdata[MB_SUSP];
      wake_en_d   = reg_wdata[MB_WAKE];
    end
    if (leave_sleep) sleep_req_d = 1'b0;
  end

  always_comb begin
    trs_d = trs_q;
    trr_d = trr_q;
    if (wr_ok && sel_set) trs_d = trs_d | reg_wdata[NMB-1:0];
    if (wr_ok && sel_rst) trr_d = trr_d | reg_wdata[NMB-1:0];
    trs_d = trs_d & ~tx_done_mb;
    trr_d = trr_d & ~abort_done_mb;
    if (enter_sleep) begin
      trs_d = '0;
      trr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_req <= 1'b0;
      susp_req  <= 1'b0;
      wake_en   <= 1'b0;
      trs_q     <= '0;
      trr_q     <= '0;
    end else begin
      sleep_req <= sleep_req_d;
      susp_req  <= susp_req_d;
      wake_en   <= wake_en_d;
      trs_q     <= trs_d;
      trr_q     <= trr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (asleep) begin
        if (sel_stat) reg_rdata = DATA_W'(SLEEP_STATUS);
      end else if (sel_mode) begin
        reg_rdata[MB_SLEEP] = sleep_req;
        reg_rdata[MB_SUSP]  = susp_req;
        reg_rdata[MB_WAKE]  = wake_en;
      end else if (sel_stat) begin
        reg_rdata = status_live;
      end else if (sel_set) begin
        reg_rdata[NMB-1:0] = trs_q;
      end else if (sel_rst) begin
        reg_rdata[NMB-1:0] = trr_q;
      end else if (sel_ext) begin
        reg_rdata = ext_rdata;
      end
    end
  end
endmodule

// File: rtl/can_lpm_seq.sv
module can_lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NMB       = 8,
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ext_wr,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              can_rx,
  input  logic              bit_stb,
  input  logic              bus_busy,
  input  logic              frm_done,
  input  logic              frm_is_tx,
  input  logic              arb_lost,
  input  logic              busoff_rec,
  input  logic              err_passive,
  input  logic [NMB-1:0]    tx_done_mb,
  input  logic [NMB-1:0]    abort_done_mb,
  output logic [NMB-1:0]    tx_req,
  output logic [NMB-1:0]    tx_abort,
  output logic              err_cnt_clr,
  output logic              tx_inhibit,
  output logic              sleep_ack,
  output logic              susp_ack,
  output logic              bus_active
);
  logic [1:0]  rst_pipe_q;
  logic        core_rst_n;
  lpm_state_e  state;
  logic        enter_sleep, leave_sleep, idle_seen, sleep_evt;
  logic        mode_wr, sleep_req, susp_req, wake_en;
  logic [DATA_W-1:0] status_live;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  lpm_frame_track u_track (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .frm_done  (frm_done),
    .frm_is_tx (frm_is_tx),
    .arb_lost  (arb_lost),
    .sleep_evt (sleep_evt)
  );

  lpm_wake_cnt #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .arm       (state == ST_WAKE),
    .bit_stb   (bit_stb),
    .can_rx    (can_rx),
    .idle_seen (idle_seen)
  );

  lpm_fsm u_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .sleep_req   (sleep_req),
    .susp_req    (susp_req),
    .wake_en     (wake_en),
    .mode_wr     (mode_wr),
    .bus_busy    (bus_busy),
    .busoff_rec  (busoff_rec),
    .frm_done    (frm_done),
    .sleep_evt   (sleep_evt),
    .bit_stb     (bit_stb),
    .can_rx      (can_rx),
    .idle_seen   (idle_seen),
    .state_q     (state),
    .enter_sleep (enter_sleep),
    .leave_sleep (leave_sleep)
  );

  assign sleep_ack   = (state == ST_SLEEP);
  assign susp_ack    = (state == ST_SUSP);
  assign tx_inhibit  = susp_ack;
  assign bus_active  = (state == ST_ACTIVE) || (state == ST_SLEEP_PEND) ||
                       (state == ST_SUSP_PEND);
  assign err_cnt_clr = enter_sleep;

  always_comb begin
    status_live               = '0;
    status_live[SB_SUSP_ACK]  = susp_ack;
    status_live[SB_ACTIVE]    = bus_active;
    status_live[SB_ERR_PASS]  = err_passive;
    status_live[SB_BUSOFF]    = busoff_rec;
    status_live[SB_BUSY]      = bus_busy;
    status_live[SB_SLEEP_ACK] = sleep_ack;
    status_live[SB_TX_IDLE]   = (tx_req == '0);
  end

  lpm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NMB(NMB)) u_regs (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .ext_wr        (ext_wr),
    .ext_rdata     (ext_rdata),
    .asleep        (sleep_ack),
    .enter_sleep   (enter_sleep),
    .leave_sleep   (leave_sleep),
    .status_live   (status_live),
    .tx_done_mb    (tx_done_mb),
    .abort_done_mb (abort_done_mb),
    .mode_wr       (mode_wr),
    .sleep_req     (sleep_req),
    .susp_req      (susp_req),
    .wake_en       (wake_en),
    .trs_q         (tx_req),
    .trr_q         (tx_abort)
  );
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NMB    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              ext_wr,
  input logic              sleep_ack,
  input logic              susp_ack,
  input logic              bus_active,
  input logic              busoff_rec,
  input logic              err_cnt_clr,
  input logic [NMB-1:0]    tx_req,
  input logic [NMB-1:0]    tx_abort
);
  p_acks_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_ack && susp_ack));

  p_no_ext_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ack && reg_wr) |-> !ext_wr);

  p_flags_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> (tx_req == '0 && tx_abort == '0));

  p_clr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt_clr |=> (sleep_ack && !err_cnt_clr));

  p_sleep_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_ack && reg_rd && reg_addr == ADDR_W'(1)) |-> reg_rdata == DATA_W'(16'hF040));

  p_idle_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_active) |-> !$past(sleep_ack));

  p_wake_off_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_ack) |-> !bus_active);

  p_busoff_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_rec && !susp_ack) |=> !susp_ack);
endmodule

bind can_lpm_seq lpm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NMB(NMB)) u_lpm_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .ext_wr      (ext_wr),
  .sleep_ack   (sleep_ack),
  .susp_ack    (susp_ack),
  .bus_active  (bus_active),
  .busoff_rec  (busoff_rec),
  .err_cnt_clr (err_cnt_clr),
  .tx_req      (tx_req),
  .tx_abort    (tx_abort)
);

// File: tb/can_lpm_seq_bench.sv
module can_lpm_seq_bench;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 16;
  localparam int unsigned NM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic ext_wr;
  logic [DW-1:0] ext_rdata = 16'h1234;
  logic can_rx = 1'b1, bit_stb = 1'b0, bus_busy = 1'b0;
  logic frm_done = 1'b0, frm_is_tx = 1'b0, arb_lost = 1'b0;
  logic busoff_rec = 1'b0, err_passive = 1'b0;
  logic [NM-1:0] tx_done_mb = '0, abort_done_mb = '0;
  logic [NM-1:0] tx_req, tx_abort;
  logic err_cnt_clr, tx_inhibit, sleep_ack, susp_ack, bus_active;

  int n_chk = 0;
  int n_err = 0;
  int n_extwr = 0;
  int n_clr = 0;

  always #4 clk = ~clk;

  can_lpm_seq u_can_lpm_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_wr(ext_wr), .ext_rdata(ext_rdata), .can_rx(can_rx),
    .bit_stb(bit_stb), .bus_busy(bus_busy), .frm_done(frm_done),
    .frm_is_tx(frm_is_tx), .arb_lost(arb_lost), .busoff_rec(busoff_rec),
    .err_passive(err_passive), .tx_done_mb(tx_done_mb),
    .abort_done_mb(abort_done_mb), .tx_req(tx_req), .tx_abort(tx_abort),
    .err_cnt_clr(err_cnt_clr), .tx_inhibit(tx_inhibit),
    .sleep_ack(sleep_ack), .susp_ack(susp_ack), .bus_active(bus_active)
  );

  always @(posedge clk) begin
    if (ext_wr)      n_extwr++;
    if (err_cnt_clr) n_clr++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic bits(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      can_rx = v; bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0; can_rx = 1'b1;
    end
  endtask

  task automatic pulse_done(input logic is_tx);
    @(negedge clk);
    frm_done = 1'b1; frm_is_tx = is_tx;
    @(negedge clk);
    frm_done = 1'b0; frm_is_tx = 1'b0;
  endtask

  task automatic wake_and_idle();
    wr(4'd0, 16'h0000);
    bits(1'b1, 11);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 bus_active", bus_active, 1);
    chk("R1 sleep_ack", sleep_ack, 0);
    chk("R1 susp_ack", susp_ack, 0);
    rd(4'd0, d); chk("R1 mode", d, 16'h0000);
    rd(4'd1, d); chk("R1 status", d, 16'h8002);
    rd(4'd2, d); chk("R1 txset", d, 0);
    rd(4'd3, d); chk("R1 txrst", d, 0);
  endtask

  task automatic t_sleep_idle();
    logic [DW-1:0] d;
    int clr0, ext0;
    wr(4'd2, 16'h0005);
    wr(4'd3, 16'h0002);
    chk("R13 set", tx_req, 8'h05);
    @(negedge clk); tx_done_mb = 8'h01;
    @(negedge clk); tx_done_mb = 8'h00;
    chk("R13 clear", tx_req, 8'h04);
    chk("R13 abort", tx_abort, 8'h02);
    clr0 = n_clr;
    wr(4'd0, 16'h0001);
    cyc(3);
    chk("R2 sleep_ack", sleep_ack, 1);
    chk("R2 bus_active", bus_active, 0);
    chk("R5 tx_req", tx_req, 0);
    chk("R5 tx_abort", tx_abort, 0);
    chk("R5 clr pulses", n_clr - clr0, 1);
    rd(4'd1, d); chk("R3 status", d, 16'hF040);
    rd(4'd0, d); chk("R3 mode", d, 16'h0000);
    rd(4'd5, d); chk("R3 ext", d, 16'h0000);
    ext0 = n_extwr;
    wr(4'd2, 16'h00FF);
    wr(4'd3, 16'h00FF);
    wr(4'd6, 16'hABCD);
    chk("R4 ext_wr", n_extwr - ext0, 0);
    chk("R4 tx_req", tx_req, 0);
    chk("R4 tx_abort", tx_abort, 0);
    chk("R4 still asleep", sleep_ack, 1);
  endtask

  task automatic t_wake_write();
    logic [DW-1:0] d;
    int ext0;
    wr(4'd0, 16'h0000);
    chk("R6 sleep_ack", sleep_ack, 0);
    chk("R6 off bus", bus_active, 0);
    rd(4'd0, d); chk("R6 mode", d, 16'h0000);
    bits(1'b1, 10);
    chk("R8 ten", bus_active, 0);
    bits(1'b0, 1);
    bits(1'b1, 10);
    chk("R8 restart", bus_active, 0);
    bits(1'b1, 1);
    chk("R8 eleventh", bus_active, 1);
    ext0 = n_extwr;
    wr(4'd6, 16'h1111);
    chk("R4 ext_wr awake", n_extwr - ext0, 1);
  endtask

  task automatic t_wake_bus();
    logic [DW-1:0] d;
    wr(4'd0, 16'h0005);
    cyc(3);
    chk("R7 asleep", sleep_ack, 1);
    bits(1'b1, 3);
    chk("R7 recessive", sleep_ack, 1);
    bits(1'b0, 1);
    chk("R7 dominant wake", sleep_ack, 0);
    rd(4'd0, d); chk("R6 mode after bus wake", d, 16'h0004);
    bits(1'b1, 11);
    chk("R8 active", bus_active, 1);
    wr(4'd0, 16'h0001);
    cyc(3);
    bits(1'b0, 1);
    chk("R7 wake disabled", sleep_ack, 1);
    wake_and_idle();
    chk("R7 back", bus_active, 1);
  endtask

  task automatic t_sleep_defer();
    bus_busy = 1'b1;
    wr(4'd0, 16'h0001);
    cyc(3);
    chk("R9 held busy", sleep_ack, 0);
    pulse_done(1'b0);
    cyc(1);
    chk("R9 plain rx", sleep_ack, 0);
    @(negedge clk); arb_lost = 1'b1;
    @(negedge clk); arb_lost = 1'b0;
    pulse_done(1'b0);
    chk("R9 rx after arb", sleep_ack, 1);
    bus_busy = 1'b0;
    wake_and_idle();
    bus_busy = 1'b1;
    wr(4'd0, 16'h0001);
    cyc(3);
    pulse_done(1'b1);
    chk("R9 tx done", sleep_ack, 1);
    bus_busy = 1'b0;
    wake_and_idle();
    chk("R9 back", bus_active, 1);
  endtask

  task automatic t_suspend();
    logic [DW-1:0] d;
    bus_busy = 1'b1;
    wr(4'd0, 16'h0002);
    cyc(3);
    chk("R10 held", susp_ack, 0);
    pulse_done(1'b0);
    chk("R10 susp_ack", susp_ack, 1);
    chk("R10 inhibit", tx_inhibit, 1);
    rd(4'd1, d); chk("R10 status bit0", d[0], 1);
    bus_busy = 1'b0;
    wr(4'd0, 16'h0000);
    cyc(1);
    chk("R12 susp_ack", susp_ack, 0);
    chk("R12 inhibit", tx_inhibit, 0);
    chk("R12 active", bus_active, 1);
  endtask

  task automatic t_susp_busoff();
    busoff_rec = 1'b1;
    wr(4'd0, 16'h0002);
    cyc(5);
    chk("R11 held", susp_ack, 0);
    busoff_rec = 1'b0;
    cyc(2);
    chk("R11 entered", susp_ack, 1);
    wr(4'd0, 16'h0000);
    cyc(1);
    chk("R12 exit", susp_ack, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_sleep_idle();
    t_wake_write();
    t_wake_bus();
    t_sleep_defer();
    t_suspend();
    t_susp_busoff();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule